// File: doc/BRIEF.md
# Infrared Carrier Modulator Timer

This block drives an infrared emitter pin. A carrier generator produces a square wave whose high and low durations are programmed separately, and a modulator counter cuts it into mark and space periods. During a mark the carrier (or, in baseband mode, a steady high) reaches the pin. During a space the pin is low. A frequency-shift mode alternates between two carrier settings on successive modulation cycles. A direct mode hands the pin to a software-written level.

All timing runs on a tick taken from the system clock through a programmable divider. Every end of a modulation cycle sets a pending flag that can raise an interrupt. An extended-space control stretches the space over whole cycles. Clearing the output-enable bit keeps the block running as a periodic interrupt source with the pin held low. Software reaches the block through a simple write port and a combinational read port.

Control register (address 0) bit layout, used by every requirement below: bits [1:0] mode (0 time, 1 baseband, 2 FSK, 3 direct), bit 2 run, bit 3 output enable, bit 4 extended space, bit 5 direct level, bit 6 interrupt enable.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset, `ir_out` and `irq` are low and the control register (address 0) reads zero.
- R2: The tick period is (D+1) clock cycles, where D is the divider value at address 1. The count restarts when run goes from 0 to 1, so every duration below is scaled by D+1 clocks.
- R3: In time mode, the carrier is high for H+1 ticks and low for L+1 ticks. H is at address 2 and L at address 3, and the two are independent. The carrier restarts in its high phase at the start of every mark, and the pin carries the carrier only during marks.
- R4: A mark lasts M+1 ticks (M at address 6) and a space lasts S ticks (S at address 7). The pin is low during a space. With S=0, marks follow each other with no gap.
- R5: In baseband mode, the pin is high for the whole mark and low for the whole space, with no carrier.
- R6: In FSK mode, the first cycle after start uses carrier pair 0 (addresses 2 and 3). Later cycles alternate with pair 1 (high at address 4, low at address 5).
- R7: A mark or space value written during a modulation cycle takes effect only from the next end of cycle.
- R8: While the extended-space bit is set, it is sampled at each end of cycle. Every cycle that starts with the bit set keeps the pin low for its whole length, while cycle timing and end-of-cycle events continue.
- R9: Each end of cycle sets a pending flag, readable at address 8 bit 0 and cleared by writing 1 to that bit. A set and a clear in the same cycle leave the flag set. `irq` is the pending flag gated by the interrupt-enable bit.
- R10: With output enable at 0, the pin stays low while the timers and the pending flag keep operating.
- R11: In direct mode, the pin follows the direct-level bit one cycle after it is written, whether run is set or not, provided output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ir_out | output | 1 | Registered infrared drive output |
| irq | output | 1 | End-of-cycle interrupt |

## Verification
The bench uses the default parameters: an 8-bit divider and carrier counters, and a 16-bit modulator counter. Short durations such as a divider of 0 or 2 and carrier counts of 1 to 4 keep each waveform within a few hundred cycles, and the full register width remains available. Run lengths of the sampled pin expose off-by-one errors in every counter. The two FSK pairs use clearly different values, so an alternation fault shows up as a wrong run length.

// File: rtl/ir_cm_pkg.sv
`timescale 1ns/1ps
package ir_cm_pkg;
  typedef enum logic [1:0] {
    MODE_TIME   = 2'd0,
    MODE_BASE   = 2'd1,
    MODE_FSK    = 2'd2,
    MODE_DIRECT = 2'd3
  } mode_e;

  localparam int ADDR_W = 4;
  localparam int NPAIR  = 2;
  localparam int CTRL_W = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CHI0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MARK  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SPACE = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

  localparam int B_RUN   = 2;
  localparam int B_OUTEN = 3;
  localparam int B_EXT   = 4;
  localparam int B_LVL   = 5;
  localparam int B_IRQEN = 6;
endpackage

// File: rtl/ir_cm_regs.sv
`timescale 1ns/1ps
module ir_cm_regs
  import ir_cm_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int CAR_W  = 8,
  parameter int MOD_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                eoc,
  output mode_e               mode,
  output logic                run,
  output logic                start,
  output logic                out_en,
  output logic                ext_req,
  output logic                dir_lvl,
  output logic                irq_en,
  output logic                irq_pend,
  output logic [PRE_W-1:0]    div_val,
  output logic [CAR_W-1:0]    car_hi [NPAIR],
  output logic [CAR_W-1:0]    car_lo [NPAIR],
  output logic [MOD_W-1:0]    mark_val,
  output logic [MOD_W-1:0]    space_val
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  div_q;
  logic [MOD_W-1:0]  mark_q, space_q;
  logic              pend_q, pend_d;
  logic              we_ctrl, we_div, we_mark, we_space, clr_pend;

  assign we_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign we_div   = wr_en && (wr_addr == A_DIV);
  assign we_mark  = wr_en && (wr_addr == A_MARK);
  assign we_space = wr_en && (wr_addr == A_SPACE);
  assign clr_pend = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (we_div) div_q <= wr_data[PRE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= '0;
    else if (we_mark) mark_q <= wr_data[MOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) space_q <= '0;
    else if (we_space) space_q <= wr_data[MOD_W-1:0];
  end

  // set wins over clear
  always_comb begin
    pend_d = pend_q;
    if (clr_pend) pend_d = 1'b0;
    if (eoc)      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] AHI = ADDR_W'(A_CHI0 + 2*p);
    localparam logic [ADDR_W-1:0] ALO = ADDR_W'(A_CHI0 + 2*p + 1);
    logic [CAR_W-1:0] hi_q, lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_q <= '0;
      else if (wr_en && (wr_addr == AHI)) hi_q <= wr_data[CAR_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_q <= '0;
      else if (wr_en && (wr_addr == ALO)) lo_q <= wr_data[CAR_W-1:0];
    end
    assign car_hi[p] = hi_q;
    assign car_lo[p] = lo_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_DIV:   rd_data[PRE_W-1:0]  = div_q;
      A_MARK:  rd_data[MOD_W-1:0]  = mark_q;
      A_SPACE: rd_data[MOD_W-1:0]  = space_q;
      A_STAT:  rd_data[0]          = pend_q;
      default: begin
        for (int p = 0; p < NPAIR; p++) begin
          if (rd_addr == ADDR_W'(A_CHI0 + 2*p))     rd_data[CAR_W-1:0] = car_hi[p];
          if (rd_addr == ADDR_W'(A_CHI0 + 2*p + 1)) rd_data[CAR_W-1:0] = car_lo[p];
        end
      end
    endcase
  end

  assign mode      = mode_e'(ctrl_q[1:0]);
  assign run       = ctrl_q[B_RUN];
  assign start     = we_ctrl && wr_data[B_RUN] && !ctrl_q[B_RUN];
  assign out_en    = ctrl_q[B_OUTEN];
  assign ext_req   = ctrl_q[B_EXT];
  assign dir_lvl   = ctrl_q[B_LVL];
  assign irq_en    = ctrl_q[B_IRQEN];
  assign irq_pend  = pend_q;
  assign div_val   = div_q;
  assign mark_val  = mark_q;
  assign space_val = space_q;
endmodule

// File: rtl/ir_cm_prescaler.sv
`timescale 1ns/1ps
module ir_cm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  // >= keeps a lowered divider from wrapping the count
  assign tick = run && (cnt_q >= div_val);

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = '0;
    else if (!run) cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ir_cm_modulator.sv
`timescale 1ns/1ps
module ir_cm_modulator
  import ir_cm_pkg::*;
#(
  parameter int MOD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  mode_e            mode,
  input  logic             ext_req,
  input  logic [MOD_W-1:0] mark_val,
  input  logic [MOD_W-1:0] space_val,
  output logic             in_mark,
  output logic             ext_hold,
  output logic             eoc,
  output logic             restart,
  output logic             sel_now,
  output logic             sel_next
);
  logic             mark_q, mark_d;
  logic [MOD_W-1:0] cnt_q, cnt_d;
  logic [MOD_W-1:0] sp_q, sp_d;
  logic             fsk_q, fsk_d;
  logic             ext_q, ext_d;
  logic             last, to_space;

  assign last     = run && tick && (cnt_q == '0);
  assign eoc      = last && (!mark_q || (sp_q == '0));
  assign to_space = last && mark_q && (sp_q != '0);
  assign restart  = start || eoc;

  always_comb begin
    mark_d = mark_q;
    cnt_d  = cnt_q;
    sp_d   = sp_q;
    fsk_d  = fsk_q;
    ext_d  = ext_q;
    if (start) begin
      mark_d = 1'b1;
      cnt_d  = mark_val;
      sp_d   = space_val;
      fsk_d  = 1'b0;
      ext_d  = ext_req;
    end else if (eoc) begin
      mark_d = 1'b1;
      cnt_d  = mark_val;
      sp_d   = space_val;
      fsk_d  = (mode == MODE_FSK) ? !fsk_q : 1'b0;
      ext_d  = ext_req;
    end else if (to_space) begin
      mark_d = 1'b0;
      cnt_d  = sp_q - 1'b1;
    end else if (run && tick) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= 1'b0;
      cnt_q  <= '0;
      sp_q   <= '0;
      fsk_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      mark_q <= mark_d;
      cnt_q  <= cnt_d;
      sp_q   <= sp_d;
      fsk_q  <= fsk_d;
      ext_q  <= ext_d;
    end
  end

  assign in_mark  = mark_q;
  assign ext_hold = ext_q;
  assign sel_now  = fsk_q;
  assign sel_next = fsk_d;
endmodule

// File: rtl/ir_cm_carrier.sv
`timescale 1ns/1ps
module ir_cm_carrier
  import ir_cm_pkg::*;
#(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic             sel_now,
  input  logic             sel_next,
  input  logic [CAR_W-1:0] car_hi [NPAIR],
  input  logic [CAR_W-1:0] car_lo [NPAIR],
  output logic             carrier
);
  logic             hi_q, hi_d;
  logic [CAR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hi_d  = hi_q;
    cnt_d = cnt_q;
    if (restart) begin
      hi_d  = 1'b1;
      cnt_d = car_hi[sel_next];
    end else if (run && tick) begin
      if (cnt_q == '0) begin
        hi_d  = !hi_q;
        cnt_d = hi_q ? car_lo[sel_now] : car_hi[sel_now];
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  assign carrier = hi_q;
endmodule

// File: rtl/ir_carrier_mod.sv
`timescale 1ns/1ps
module ir_carrier_mod
  import ir_cm_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int CAR_W  = 8,
  parameter int MOD_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ir_out,
  output logic              irq
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  mode_e            mode;
  logic             run, start, out_en, ext_req, dir_lvl, irq_en, irq_pend;
  logic [PRE_W-1:0] div_val;
  logic [CAR_W-1:0] car_hi [NPAIR];
  logic [CAR_W-1:0] car_lo [NPAIR];
  logic [MOD_W-1:0] mark_val, space_val;
  logic             tick, in_mark, ext_hold, eoc, restart, sel_now, sel_next;
  logic             carrier, env, out_d, out_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ir_cm_regs #(.PRE_W(PRE_W), .CAR_W(CAR_W), .MOD_W(MOD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .eoc(eoc),
    .mode(mode), .run(run), .start(start), .out_en(out_en), .ext_req(ext_req),
    .dir_lvl(dir_lvl), .irq_en(irq_en), .irq_pend(irq_pend), .div_val(div_val),
    .car_hi(car_hi), .car_lo(car_lo), .mark_val(mark_val), .space_val(space_val)
  );

  ir_cm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .start(start),
    .div_val(div_val), .tick(tick)
  );

  ir_cm_modulator #(.MOD_W(MOD_W)) u_mod (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .start(start), .tick(tick),
    .mode(mode), .ext_req(ext_req), .mark_val(mark_val), .space_val(space_val),
    .in_mark(in_mark), .ext_hold(ext_hold), .eoc(eoc), .restart(restart),
    .sel_now(sel_now), .sel_next(sel_next)
  );

  ir_cm_carrier #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick), .restart(restart),
    .sel_now(sel_now), .sel_next(sel_next), .car_hi(car_hi), .car_lo(car_lo),
    .carrier(carrier)
  );

  assign env = in_mark && !ext_hold;

  always_comb begin
    out_d = 1'b0;
    case (mode)
      MODE_DIRECT: out_d = dir_lvl;
      MODE_BASE:   out_d = run && env;
      default:     out_d = run && env && carrier;
    endcase
    if (!out_en) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= 1'b0;
    else             out_q <= out_d;
  end

  assign ir_out = out_q;
  assign irq    = irq_pend && irq_en;
endmodule

// File: rtl/ir_cm_chk.sv
`timescale 1ns/1ps
module ir_cm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       run,
  input logic       out_en,
  input logic       dir_lvl,
  input logic       irq_en,
  input logic       in_mark,
  input logic       ext_hold,
  input logic       eoc,
  input logic       ir_out,
  input logic       irq
);
  AST_SPACE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode != 2'd3 && !in_mark) |=> !ir_out); // R4

  AST_BASEBAND_ENV: assert property (@(posedge clk) disable iff (!rst_n)
    (run && out_en && mode == 2'd1) |=> (ir_out == $past(in_mark && !ext_hold))); // R5

  AST_EXT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode != 2'd3 && ext_hold) |=> !ir_out); // R8

  AST_IRQ_ON_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> (irq == irq_en)); // R9

  AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !ir_out); // R10

  AST_DIRECT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && out_en) |=> (ir_out == $past(dir_lvl))); // R11
endmodule

bind ir_carrier_mod ir_cm_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mode(mode), .run(run), .out_en(out_en),
  .dir_lvl(dir_lvl), .irq_en(irq_en), .in_mark(in_mark), .ext_hold(ext_hold),
  .eoc(eoc), .ir_out(ir_out), .irq(irq)
);

// File: tb/ir_carrier_mod_bench.sv
`timescale 1ns/1ps
module ir_carrier_mod_bench;
  localparam int NS = 1024;
  localparam int C_RUN = 4, C_OE = 8, C_EXT = 16, C_LVL = 32, C_IE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ir_out, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit samp [NS];

  always #2.5 clk = ~clk;

  ir_carrier_mod u_ir_carrier_mod (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ir_out(ir_out), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input int a, output int d);
    rd_addr = 4'(a);
    #0.1;
    d = int'(rd_data);
  endtask

  task automatic capture(input int n);
    samp[0] = ir_out;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      samp[i] = ir_out;
    end
  endtask

  function automatic int nth_run(input bit v, input int k, input int n);
    int idx = 0;
    int i = 1;
    while (i < n) begin
      if (samp[i] == v && samp[i-1] != v) begin
        int j = i;
        while (j < n && samp[j] == v) j++;
        if (j >= n) return -1;
        if (idx == k) return j - i;
        idx++;
        i = j;
      end else i++;
    end
    return -1;
  endfunction

  function automatic int count_high(input int from, input int n);
    int c = 0;
    for (int i = from; i < n; i++) c += int'(samp[i]);
    return c;
  endfunction

  task automatic setup(input int dv, input int h0, input int l0, input int h1,
                       input int l1, input int mk, input int sp);
    wreg(0, 0);
    wreg(8, 1);
    wreg(1, dv); wreg(2, h0); wreg(3, l0); wreg(4, h1); wreg(5, l1);
    wreg(6, mk); wreg(7, sp);
  endtask

  task automatic t_reset;
    int d;
    rreg(0, d);
    chk("R1 ctrl", d, 0);
    chk("R1 ir_out", int'(ir_out), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_time;
    setup(0, 2, 4, 0, 0, 15, 8);
    wreg(0, 0 | C_RUN | C_OE);
    capture(120);
    chk("R3 carrier high", nth_run(1'b1, 0, 120), 3);
    chk("R3 carrier low", nth_run(1'b0, 0, 120), 5);
    chk("R4 low plus space", nth_run(1'b0, 1, 120), 13);
  endtask

  task automatic t_prescale;
    setup(2, 0, 0, 0, 0, 1, 2);
    wreg(0, 1 | C_RUN | C_OE);
    capture(80);
    chk("R2 mark scaled", nth_run(1'b1, 0, 80), 6);
    chk("R2 space scaled", nth_run(1'b0, 0, 80), 6);
  endtask

  task automatic t_baseband;
    setup(0, 0, 0, 0, 0, 4, 3);
    wreg(0, 1 | C_RUN | C_OE);
    capture(60);
    chk("R5 mark high", nth_run(1'b1, 0, 60), 5);
    chk("R5 space low", nth_run(1'b0, 0, 60), 3);
  endtask

  task automatic t_no_space;
    setup(0, 0, 0, 0, 0, 2, 0);
    wreg(0, 1 | C_RUN | C_OE);
    capture(40);
    chk("R4 zero space stays high", count_high(1, 40), 39);
  endtask

  task automatic t_fsk;
    setup(0, 1, 1, 3, 3, 11, 4);
    wreg(0, 2 | C_RUN | C_OE);
    capture(120);
    chk("R6 pair0 first", nth_run(1'b1, 0, 120), 2);
    chk("R6 pair1 second", nth_run(1'b1, 3, 120), 4);
    chk("R6 pair0 third", nth_run(1'b1, 5, 120), 2);
  endtask

  task automatic t_shadow;
    setup(0, 0, 0, 0, 0, 3, 2);
    wreg(0, 1 | C_RUN | C_OE);
    fork
      capture(60);
      begin @(negedge clk); wreg(6, 7); end
    join
    chk("R7 current mark kept", nth_run(1'b1, 0, 60), 4);
    chk("R7 next mark new", nth_run(1'b1, 1, 60), 8);
  endtask

  task automatic t_ext;
    int d;
    setup(0, 0, 0, 0, 0, 3, 3);
    wreg(0, 1 | C_RUN | C_OE);
    wreg(0, 1 | C_RUN | C_OE | C_EXT);
    capture(60);
    chk("R8 extended space low", count_high(8, 60), 0);
    rreg(8, d);
    chk("R8 cycles continue", d, 1);
    wreg(0, 1 | C_RUN | C_OE);
    capture(30);
    chk("R8 marks resume", int'(count_high(0, 30) >= 4), 1);
  endtask

  task automatic t_irq;
    int d;
    setup(0, 0, 0, 0, 0, 3, 3);
    wreg(0, 1 | C_RUN | C_OE | C_IE);
    repeat (3) @(negedge clk);
    chk("R9 irq before eoc", int'(irq), 0);
    repeat (7) @(negedge clk);
    chk("R9 irq after eoc", int'(irq), 1);
    wreg(0, 1 | C_OE | C_IE);
    wreg(8, 1);
    chk("R9 cleared", int'(irq), 0);
    wreg(0, 1 | C_RUN | C_OE);
    repeat (20) @(negedge clk);
    chk("R9 masked irq", int'(irq), 0);
    rreg(8, d);
    chk("R9 pending readable", d, 1);
  endtask

  task automatic t_out_off;
    int d;
    setup(0, 0, 0, 0, 0, 3, 3);
    wreg(0, 0 | C_RUN | C_IE);
    capture(60);
    chk("R10 pin held low", count_high(0, 60), 0);
    rreg(8, d);
    chk("R10 timer still runs", d, 1);
    chk("R10 irq still raised", int'(irq), 1);
  endtask

  task automatic t_direct;
    wreg(0, 3 | C_OE | C_LVL);
    @(negedge clk);
    chk("R11 level high", int'(ir_out), 1);
    wreg(0, 3 | C_OE);
    @(negedge clk);
    chk("R11 level low", int'(ir_out), 0);
    wreg(0, 3 | C_LVL);
    @(negedge clk);
    chk("R11 gated by enable", int'(ir_out), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_time;
    t_prescale;
    t_baseband;
    t_no_space;
    t_fsk;
    t_shadow;
    t_ext;
    t_irq;
    t_out_off;
    t_direct;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule